// File: doc/BRIEF.md
# Reversible Decimal Digit Counter

This block is one decimal digit of a counter. It holds a value from 0 to 9 in 8421 BCD and moves one step on each rising clock edge while its active-low enable is asserted. A direction input chooses whether it steps up or down, and the count wraps at either end of the decade. An active-low preset input forces the output to a 4-bit value straight away, without waiting for a clock edge. This allows the digit to be used as a loadable divider stage.

Two outputs let several digits be chained. The terminal-count flag goes high at the last value of the decade in the current direction. The active-low ripple output pulses low during the low half of the clock when the digit is enabled and about to wrap. A higher digit that is enabled by the lower digit's enable and terminal count advances exactly when the lower digit wraps. If an out-of-range code (10 to 15) is preset, the digit returns to a legal value on its first counting step.

Top module: `bcd_updown_digit`

## Requirements
- R1: While rst_n is low, q reads 0. With load_n high, q stays 0 until the first enabled count edge after reset is released.
- R2: When down is 0 (count up), load_n is high and cnt_en_n is low, each rising edge moves q from k to k+1 for k in 0..8.
- R3: When counting up, q moves from 9 to 0 on the next enabled edge.
- R4: When down is 1 (count down) and the block is enabled, q moves from k to k-1 for k in 1..9, and from 0 to 9.
- R5: When cnt_en_n is high and load_n is high, q keeps its value across clock edges. This applies to legal and illegal codes alike.
- R6: While load_n is low, q equals preset_d with no clock edge needed, and the preset overrides counting. If load_n is held low across a rising edge, the value is kept after load_n returns high.
- R7: term_cnt is 1 exactly when down is 0 and q is 9, or when down is 1 and q is 0, whatever the state of cnt_en_n.
- R8: ripple_n is 0 only while clk is low, cnt_en_n is low and term_cnt is 1. Otherwise it is 1.
- R9: From a preset code in the range 10..15, one enabled step goes to 0 when counting up and to 9 when counting down.
- R10: Take two digits on one clock. The upper digit's cnt_en_n is driven low only while the lower digit is enabled and its term_cnt is 1. The pair then counts 00 to 99 and wraps to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_n | input | 1 | Active-low asynchronous preset |
| preset_d | input | 4 | Value forced onto q while load_n is low |
| cnt_en_n | input | 1 | Active-low count enable |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| q | output | 4 | Current BCD digit |
| term_cnt | output | 1 | High at 9 counting up or at 0 counting down |
| ripple_n | output | 1 | Active-low cascade pulse during the clock-low phase |

## Verification
The hardest behaviour to reach is the preset arriving between clock edges. The bench raises load_n's assertion on the falling edge and checks q before the next rising edge. It then holds the preset through that edge and checks that the value survives the release. Illegal codes can only be reached through the preset path, so each code is loaded with counting disabled and then stepped once in each direction. The ripple pulse exists only in the clock-low half. It is therefore sampled once after a rising edge and once after a falling edge, with the enable and terminal count set up beforehand.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/bcd_rst_sync.sv
`timescale 1ns/1ps
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/bcd_step.sv
`timescale 1ns/1ps
module bcd_step
  import bcd_pkg::*;
#(
  parameter int W   = DIGIT_W,
  parameter int MAX = DIGIT_MAX
) (
  input  logic [W-1:0] cur,
  input  dir_e         dir,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = W'(MAX);

  always_comb begin
    if (dir == DIR_UP) begin
      nxt = (cur >= TOP) ? '0 : cur + W'(1);
    end else begin
      nxt = (cur == '0 || cur > TOP) ? TOP : cur - W'(1);
    end
  end
endmodule

// File: rtl/bcd_cascade.sv
`timescale 1ns/1ps
module bcd_cascade
  import bcd_pkg::*;
#(
  parameter int W   = DIGIT_W,
  parameter int MAX = DIGIT_MAX
) (
  input  logic         clk,
  input  logic [W-1:0] cur,
  input  dir_e         dir,
  input  logic         cnt_en_n,
  output logic         tc,
  output logic         ripple_n
);
  localparam logic [W-1:0] TOP = W'(MAX);

  assign tc       = (dir == DIR_UP) ? (cur == TOP) : (cur == '0);
  assign ripple_n = ~(~cnt_en_n & tc & ~clk);
endmodule

// File: rtl/bcd_updown_digit.sv
`timescale 1ns/1ps
module bcd_updown_digit
  import bcd_pkg::*;
#(
  parameter int W   = DIGIT_W,
  parameter int MAX = DIGIT_MAX
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] preset_d,
  input  logic         cnt_en_n,
  input  logic         down,
  output logic [W-1:0] q,
  output logic         term_cnt,
  output logic         ripple_n
);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic         rst_q;
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nx;
  logic [W-1:0] step_val;
  logic         cnt_ce;
  dir_e         dir;

  assign dir = dir_e'(down);

  bcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  bcd_step #(.W(W), .MAX(MAX)) u_step (
    .cur (cnt_r),
    .dir (dir),
    .nxt (step_val)
  );

  // next state: preset wins over counting
  assign cnt_ce = ~load_n | ~cnt_en_n;

  always_comb begin
    if (!load_n) cnt_nx = preset_d;
    else         cnt_nx = step_val;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      cnt_r <= '0;
    else if (cnt_ce) cnt_r <= cnt_nx;
  end

  // preset appears on the output without waiting for an edge
  assign q = load_n ? cnt_r : preset_d;

  bcd_cascade #(.W(W), .MAX(MAX)) u_casc (
    .clk      (clk),
    .cur      (q),
    .dir      (dir),
    .cnt_en_n (cnt_en_n),
    .tc       (term_cnt),
    .ripple_n (ripple_n)
  );

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (load_n && !cnt_en_n && !down && cnt_r < TOP) |=> (cnt_r == $past(cnt_r) + W'(1)));

  assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (load_n && !cnt_en_n && !down && cnt_r == TOP) |=> (cnt_r == '0));

  assert_wrap_dn_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (load_n && !cnt_en_n && down && cnt_r == '0) |=> (cnt_r == TOP));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (load_n && cnt_en_n) |=> $stable(cnt_r));

  assert_preset_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (!load_n) |=> (cnt_r == $past(preset_d)));

  assert_legal_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (load_n && !cnt_en_n) |=> (cnt_r <= TOP));
endmodule

// File: tb/tb_bcd_updown_digit.sv
`timescale 1ns/1ps
module tb_bcd_updown_digit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_n;
  logic [3:0] preset_d;
  logic       cnt_en_n;
  logic       down;
  logic [3:0] q;
  logic       term_cnt;
  logic       ripple_n;

  // cascade pair
  logic       c_en_n;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc, lo_rn, hi_rn;
  logic       hi_en_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bcd_updown_digit dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset_d(preset_d),
    .cnt_en_n(cnt_en_n), .down(down), .q(q), .term_cnt(term_cnt), .ripple_n(ripple_n)
  );

  assign hi_en_n = ~(~c_en_n & lo_tc);

  bcd_updown_digit cas_lo (
    .clk(clk), .rst_n(rst_n), .load_n(1'b1), .preset_d(4'd0),
    .cnt_en_n(c_en_n), .down(1'b0), .q(lo_q), .term_cnt(lo_tc), .ripple_n(lo_rn)
  );

  bcd_updown_digit cas_hi (
    .clk(clk), .rst_n(rst_n), .load_n(1'b1), .preset_d(4'd0),
    .cnt_en_n(hi_en_n), .down(1'b0), .q(hi_q), .term_cnt(hi_tc), .ripple_n(hi_rn)
  );

  task automatic chk(input int req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // fields: ld_n, preset, en_n, down, exp_q, exp_tc, req
  localparam int NV = 33;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1,4'd0,1'b0,1'b0,4'd1,1'b0,4'd2},   // R2 count up
    {1'b1,4'd0,1'b0,1'b0,4'd2,1'b0,4'd2},
    {1'b1,4'd0,1'b0,1'b0,4'd3,1'b0,4'd2},
    {1'b1,4'd0,1'b0,1'b0,4'd4,1'b0,4'd2},
    {1'b1,4'd0,1'b0,1'b0,4'd5,1'b0,4'd2},
    {1'b1,4'd0,1'b0,1'b0,4'd6,1'b0,4'd2},
    {1'b1,4'd0,1'b0,1'b0,4'd7,1'b0,4'd2},
    {1'b1,4'd0,1'b0,1'b0,4'd8,1'b0,4'd2},
    {1'b1,4'd0,1'b0,1'b0,4'd9,1'b1,4'd7},   // R7 tc at 9 up
    {1'b1,4'd0,1'b0,1'b0,4'd0,1'b0,4'd3},   // R3 wrap up
    {1'b1,4'd0,1'b1,1'b0,4'd0,1'b0,4'd5},   // R5 hold
    {1'b1,4'd0,1'b1,1'b0,4'd0,1'b0,4'd5},
    {1'b1,4'd0,1'b0,1'b1,4'd9,1'b0,4'd4},   // R4 wrap down
    {1'b1,4'd0,1'b0,1'b1,4'd8,1'b0,4'd4},
    {1'b1,4'd0,1'b0,1'b1,4'd7,1'b0,4'd4},
    {1'b1,4'd0,1'b0,1'b1,4'd6,1'b0,4'd4},
    {1'b1,4'd0,1'b0,1'b1,4'd5,1'b0,4'd4},
    {1'b1,4'd0,1'b0,1'b1,4'd4,1'b0,4'd4},
    {1'b1,4'd0,1'b0,1'b1,4'd3,1'b0,4'd4},
    {1'b1,4'd0,1'b0,1'b1,4'd2,1'b0,4'd4},
    {1'b1,4'd0,1'b0,1'b1,4'd1,1'b0,4'd4},
    {1'b1,4'd0,1'b0,1'b1,4'd0,1'b1,4'd7},   // R7 tc at 0 down
    {1'b1,4'd0,1'b0,1'b1,4'd9,1'b0,4'd4},
    {1'b1,4'd0,1'b1,1'b1,4'd9,1'b0,4'd5},   // R5 hold
    {1'b0,4'd5,1'b0,1'b1,4'd5,1'b0,4'd6},   // R6 preset beats count
    {1'b1,4'd0,1'b0,1'b1,4'd4,1'b0,4'd4},
    {1'b0,4'd12,1'b1,1'b0,4'd12,1'b0,4'd9}, // R9 illegal codes
    {1'b1,4'd0,1'b0,1'b0,4'd0,1'b0,4'd9},
    {1'b0,4'd14,1'b1,1'b1,4'd14,1'b0,4'd9},
    {1'b1,4'd0,1'b0,1'b1,4'd9,1'b0,4'd9},
    {1'b0,4'd15,1'b1,1'b0,4'd15,1'b0,4'd9},
    {1'b1,4'd0,1'b1,1'b0,4'd15,1'b0,4'd5},
    {1'b1,4'd0,1'b0,1'b0,4'd0,1'b0,4'd9}
  };

  initial begin
    rst_n = 1'b0; load_n = 1'b1; preset_d = 4'd0;
    cnt_en_n = 1'b0; down = 1'b0; c_en_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(1, q, 0, "q in reset");
    chk(7, term_cnt, 0, "tc in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(1, q, 0, "q after release");
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      load_n   = VEC[i][15];
      preset_d = VEC[i][14:11];
      cnt_en_n = VEC[i][10];
      down     = VEC[i][9];
      @(posedge clk); #1;
      chk(int'(VEC[i][3:0]), q, int'(VEC[i][8:5]), $sformatf("vector %0d q", i));
      chk(int'(VEC[i][3:0]), term_cnt, int'(VEC[i][4]), $sformatf("vector %0d tc", i));
    end

    // R6 preset between edges
    load_n = 1'b1; cnt_en_n = 1'b1; down = 1'b0;
    @(negedge clk); #1;
    preset_d = 4'd7; load_n = 1'b0;
    #1;
    chk(6, q, 7, "mid-cycle preset");
    @(posedge clk); #1;
    load_n = 1'b1; #1;
    chk(6, q, 7, "preset kept after release");
    @(posedge clk); #1;
    chk(5, q, 7, "hold after preset");

    // R7 tc independent of enable, follows direction
    preset_d = 4'd9; load_n = 1'b0; #1;
    chk(7, term_cnt, 1, "tc 9 up disabled");
    down = 1'b1; #1;
    chk(7, term_cnt, 0, "tc 9 down");
    preset_d = 4'd0; #1;
    chk(7, term_cnt, 1, "tc 0 down disabled");
    @(posedge clk); #1;
    load_n = 1'b1;

    // R8 ripple pulse
    @(negedge clk); #1;
    chk(8, ripple_n, 1, "ripple with enable off");
    @(posedge clk); #1;
    cnt_en_n = 1'b0; #1;
    chk(8, ripple_n, 1, "ripple in clk high");
    @(negedge clk); #1;
    chk(8, ripple_n, 0, "ripple in clk low");
    @(posedge clk); #1;
    chk(4, q, 9, "down wrap after ripple");
    cnt_en_n = 1'b1;
    @(negedge clk); #1;
    chk(8, ripple_n, 1, "ripple after wrap");

    // R10 two-digit cascade
    @(posedge clk); #1;
    c_en_n = 1'b0;
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk); #1;
      chk(10, int'(hi_q) * 10 + int'(lo_q), k % 100, "cascade value");
      if (k == 99) chk(10, int'(lo_tc & hi_tc), 1, "both tc at 99");
    end
    c_en_n = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule